// File: doc/BRIEF.md
# Escaped Frame Transmitter with Checksum

This block turns a message held in an external mailbox buffer into a byte stream on a serial link, one byte per valid/ready handshake. The buffer holds, from address 0 upward, a length byte, the network-function/LUN byte, the sequence byte, the command byte and any data bytes. The block reads the buffer through an asynchronous read port and drops the length byte. It sends the remaining bytes with the network-function and sequence bytes exchanged. Any reserved byte value is byte-stuffed. A checksum follows the payload, and a raw end-of-message marker closes the frame.

A connect event makes the block send a fixed three-byte version command frame. A request that arrives while a frame is on the link is remembered and started once that frame's last byte has been accepted. If a version frame and a message frame are both waiting, the version frame goes first. A one-cycle done pulse follows the acceptance of every frame's terminator. The mailbox owner must keep the buffer contents unchanged from the request until the matching done pulse.

Top module: `esc_frame_tx`

## Requirements
- R1: After reset, tx_valid_o and done_o are low and no byte is offered until a request or connect event arrives.
- R2: A message request with count N sends the buffered bytes at addresses 1..N-1, never address 0, in the order 2, 1, 3, 4, ..., N-1 when N >= 3. With N = 2 only address 1 is sent.
- R3: Each of the reserved values 0xA0, 0xA1 and 0xAA, when it occurs in the payload or as the checksum, is sent as the two bytes 0xAA followed by the value ORed with 0x10 (0xB0, 0xB1, 0xBA). All other values are sent as they are.
- R4: After the payload a message frame carries one checksum byte equal to the two's-complement negation of the modulo-256 sum of the unstuffed payload bytes, so that payload plus checksum sums to zero.
- R5: A message frame ends with a single raw 0xA0. No raw 0xA0 or 0xA1 appears anywhere else in any frame.
- R6: A pulse on conn_i produces the frame 0xFF, 0x01, 0xA1, with no checksum.
- R7: A request that arrives while a frame is being sent is held, and its frame starts only after the current frame's terminator has been accepted.
- R8: done_o is high for exactly the one cycle that follows the handshake of a frame's terminator byte, and at no other time.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o keeps its value in the next cycle.
- R10: When a connect event and a message request are both waiting, including when they arrive in the same cycle, the version frame is sent first and the message frame right after it.
- R11: A message request with count 0 or 1 sends only the checksum 0x00 and the terminator 0xA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_i | input | 1 | One-cycle connect event; requests the version frame |
| send_i | input | 1 | One-cycle request to send the buffered message |
| msg_cnt_i | input | CW (7) | Number of buffered bytes including the length byte, sampled with send_i |
| rd_addr_o | output | AW (6) | Buffer read address |
| rd_data_i | input | 8 | Buffer read data for rd_addr_o, same cycle |
| tx_valid_o | output | 1 | A link byte is offered |
| tx_ready_i | input | 1 | Link accepts the offered byte |
| tx_data_o | output | 8 | Offered link byte |
| done_o | output | 1 | One-cycle pulse after a frame terminator is accepted |

## Verification
The two functions that can meet in one cycle are the version-frame path and the message-frame path. The bench raises conn_i and send_i on the same clock edge and also issues a second message request while a frame is still draining under a stalling link. Each case is judged by comparing the whole captured byte stream against two frames built independently, in the required order, and by counting exactly one done pulse per terminator.

// File: rtl/eftx_pkg.sv
package eftx_pkg;

    localparam logic [7:0] END_MSG  = 8'hA0;
    localparam logic [7:0] END_CMD  = 8'hA1;
    localparam logic [7:0] ESC_BYTE = 8'hAA;
    localparam logic [7:0] ESC_FLIP = 8'h10;
    localparam logic [7:0] VER_CMD  = 8'hFF;
    localparam logic [7:0] VER_NUM  = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_CKSUM,
        ST_TERM
    } tx_state_e;

    function automatic logic is_reserved(input logic [7:0] b);
        return (b == END_MSG) || (b == END_CMD) || (b == ESC_BYTE);
    endfunction

endpackage

// File: rtl/eftx_addr_map.sv
module eftx_addr_map #(
    parameter int AW = 6,
    parameter int CW = 7
) (
    input  logic [AW-1:0] pos_i,
    input  logic [CW-1:0] cnt_i,
    output logic [AW-1:0] addr_o
);
    // Positions 1 and 2 trade places only when both exist.
    logic swap_ok;

    always_comb begin
        swap_ok = (cnt_i >= CW'(3));
        addr_o  = pos_i;
        if (swap_ok && pos_i == AW'(1)) begin
            addr_o = AW'(2);
        end else if (swap_ok && pos_i == AW'(2)) begin
            addr_o = AW'(1);
        end
    end
endmodule

// File: rtl/eftx_stuffer.sv
module eftx_stuffer
    import eftx_pkg::*;
(
    input  logic [7:0] raw_i,
    input  logic       second_i,
    output logic [7:0] out_o,
    output logic       need_esc_o
);
    always_comb begin
        need_esc_o = is_reserved(raw_i);
        if (second_i) begin
            out_o = raw_i | ESC_FLIP;
        end else if (need_esc_o) begin
            out_o = ESC_BYTE;
        end else begin
            out_o = raw_i;
        end
    end
endmodule

// File: rtl/eftx_cksum.sv
module eftx_cksum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic [7:0] neg_o
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr_i) begin
            sum_d = 8'h00;
        end else if (add_i) begin
            sum_d = sum_q + byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= 8'h00;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign neg_o = 8'h00 - sum_q;

    // R4: a clear leaves a zero checksum for an empty payload
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (neg_o == 8'h00));
endmodule

// File: rtl/esc_frame_tx.sv
module esc_frame_tx
    import eftx_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    localparam int AW = $clog2(BUF_DEPTH),
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conn_i,
    input  logic          send_i,
    input  logic [CW-1:0] msg_cnt_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          tx_valid_o,
    input  logic          tx_ready_i,
    output logic [7:0]    tx_data_o,
    output logic          done_o
);

    typedef struct packed {
        tx_state_e     state;
        logic          is_ver;
        logic [AW-1:0] pos;
        logic [CW-1:0] cnt;
        logic          second;
        logic          done;
        logic          ver_pend;
        logic          msg_pend;
        logic [CW-1:0] pend_cnt;
    } st_t;

    st_t st_d, st_q;

    logic       accept;
    logic       ck_clr, ck_add;
    logic [7:0] ck_neg;
    logic [7:0] raw_byte;
    logic [7:0] stuffed;
    logic       need_esc;
    logic       body_last;

    eftx_addr_map #(.AW(AW), .CW(CW)) u_map (
        .pos_i  (st_q.pos),
        .cnt_i  (st_q.cnt),
        .addr_o (rd_addr_o)
    );

    eftx_stuffer u_stuff (
        .raw_i      (raw_byte),
        .second_i   (st_q.second),
        .out_o      (stuffed),
        .need_esc_o (need_esc)
    );

    eftx_cksum u_ck (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ck_clr),
        .add_i  (ck_add),
        .byte_i (raw_byte),
        .neg_o  (ck_neg)
    );

    // Unstuffed byte for the current position
    always_comb begin
        if (st_q.state == ST_CKSUM) begin
            raw_byte = ck_neg;
        end else if (st_q.is_ver) begin
            raw_byte = (st_q.pos == AW'(0)) ? VER_CMD : VER_NUM;
        end else begin
            raw_byte = rd_data_i;
        end
    end

    assign tx_valid_o = (st_q.state != ST_IDLE);
    assign tx_data_o  = (st_q.state == ST_TERM) ? (st_q.is_ver ? END_CMD : END_MSG)
                                                : stuffed;
    assign done_o     = st_q.done;
    assign accept     = tx_valid_o && tx_ready_i;
    assign body_last  = st_q.is_ver ? (st_q.pos == AW'(1))
                                    : ({1'b0, st_q.pos} + CW'(1) == st_q.cnt);

    always_comb begin
        st_d   = st_q;
        st_d.done = 1'b0;
        ck_clr = 1'b0;
        ck_add = 1'b0;

        if (conn_i) begin
            st_d.ver_pend = 1'b1;
        end
        if (send_i) begin
            st_d.msg_pend = 1'b1;
            st_d.pend_cnt = msg_cnt_i;
        end

        case (st_q.state)
            ST_IDLE: begin
                if (st_d.ver_pend) begin
                    st_d.ver_pend = 1'b0;
                    st_d.is_ver   = 1'b1;
                    st_d.pos      = AW'(0);
                    st_d.second   = 1'b0;
                    st_d.state    = ST_BODY;
                end else if (st_d.msg_pend) begin
                    st_d.msg_pend = 1'b0;
                    st_d.is_ver   = 1'b0;
                    st_d.cnt      = st_d.pend_cnt;
                    st_d.pos      = AW'(1);
                    st_d.second   = 1'b0;
                    ck_clr        = 1'b1;
                    st_d.state    = (st_d.pend_cnt <= CW'(1)) ? ST_CKSUM : ST_BODY;
                end
            end
            ST_BODY: begin
                if (accept) begin
                    if (need_esc && !st_q.second) begin
                        st_d.second = 1'b1;
                    end else begin
                        st_d.second = 1'b0;
                        ck_add      = !st_q.is_ver;
                        if (body_last) begin
                            st_d.state = st_q.is_ver ? ST_TERM : ST_CKSUM;
                        end else begin
                            st_d.pos = st_q.pos + AW'(1);
                        end
                    end
                end
            end
            ST_CKSUM: begin
                if (accept) begin
                    if (need_esc && !st_q.second) begin
                        st_d.second = 1'b1;
                    end else begin
                        st_d.second = 1'b0;
                        st_d.state  = ST_TERM;
                    end
                end
            end
            ST_TERM: begin
                if (accept) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R9: an offered byte is held until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R3: an accepted escape prefix is followed by a flipped reserved value
    p_esc_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && tx_data_o == ESC_BYTE) |=>
        (tx_valid_o && (tx_data_o == 8'hB0 || tx_data_o == 8'hB1 || tx_data_o == 8'hBA)));

    // R5: raw end markers only in the terminator slot
    p_no_raw_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && st_q.state != ST_TERM) |-> (tx_data_o != END_MSG && tx_data_o != END_CMD));

    // R8: done follows a terminator handshake and lasts one cycle
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(tx_valid_o && tx_ready_i &&
                          (tx_data_o == END_MSG || tx_data_o == END_CMD)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: version frame wins when both kinds are waiting
    p_ver_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && st_q.ver_pend && st_q.msg_pend) |=> st_q.is_ver);

endmodule

// File: tb/tb_esc_frame_tx.sv
module tb_esc_frame_tx;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conn_i = 1'b0;
    logic          send_i = 1'b0;
    logic [CW-1:0] msg_cnt_i = '0;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    rd_data_i;
    logic          tx_valid_o;
    logic          tx_ready_i = 1'b1;
    logic [7:0]    tx_data_o;
    logic          done_o;

    logic [7:0] mem [DEPTH];
    logic [7:0] got_q [$];
    logic [7:0] exp_q [$];
    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    int hold_err = 0;
    int cyc = 0;
    logic stall_mode = 1'b0;
    logic [7:0] lfsr = 8'h5B;
    logic term_seen = 1'b0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;

    assign rd_data_i = mem[rd_addr_o];

    esc_frame_tx #(.BUF_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .conn_i(conn_i), .send_i(send_i),
        .msg_cnt_i(msg_cnt_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
        .done_o(done_o)
    );

    always #5 clk = ~clk;

    // Link ready pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready_i = stall_mode ? lfsr[0] : 1'b1;
    end

    // Monitor: capture, hold check, done check (R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (term_seen) begin
                checks++;
                if (!done_o) begin
                    failures++;
                    $display("FAIL R8: done_o=%0b expected 1 after terminator", done_o);
                end
            end else if (done_o) begin
                checks++;
                failures++;
                $display("FAIL R8: done_o=1 expected 0 (no terminator)");
            end
            if (done_o) done_cnt++;
            if (prev_stall && (!tx_valid_o || tx_data_o != prev_data)) hold_err++;
            term_seen = tx_valid_o && tx_ready_i &&
                        (tx_data_o == 8'hA0 || tx_data_o == 8'hA1);
            if (tx_valid_o && tx_ready_i) got_q.push_back(tx_data_o);
            prev_stall = tx_valid_o && !tx_ready_i;
            prev_data  = tx_data_o;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
            summary();
        end
    end

    task automatic push_enc(input logic [7:0] b);
        if (b == 8'hA0 || b == 8'hA1 || b == 8'hAA) begin
            exp_q.push_back(8'hAA);
            exp_q.push_back(b | 8'h10);
        end else begin
            exp_q.push_back(b);
        end
    endtask

    task automatic add_msg(input int n);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 1; k < n; k++) begin
            int a;
            a = k;
            if (n >= 3 && k == 1) a = 2;
            else if (n >= 3 && k == 2) a = 1;
            push_enc(mem[a]);
            s = s + mem[a];
        end
        push_enc(8'h00 - s);
        exp_q.push_back(8'hA0);
    endtask

    task automatic add_ver();
        exp_q.push_back(8'hFF);
        exp_q.push_back(8'h01);
        exp_q.push_back(8'hA1);
    endtask

    task automatic pulse(input logic c, input logic s, input int n);
        @(posedge clk); #2;
        conn_i = c; send_i = s; msg_cnt_i = CW'(n);
        @(posedge clk); #2;
        conn_i = 1'b0; send_i = 1'b0;
    endtask

    task automatic wait_done(input int n);
        int target;
        target = done_cnt + n;
        while (done_cnt < target) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic compare(input string req);
        checks++;
        if (got_q.size() != exp_q.size()) begin
            failures++;
            $display("FAIL %s: frame length %0d expected %0d", req, got_q.size(), exp_q.size());
        end else begin
            for (int k = 0; k < got_q.size(); k++) begin
                if (got_q[k] != exp_q[k]) begin
                    failures++;
                    $display("FAIL %s: byte %0d = %02h expected %02h", req, k, got_q[k], exp_q[k]);
                    break;
                end
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (tx_valid_o !== 1'b0 || done_o !== 1'b0) begin
            failures++;
            $display("FAIL R1: valid=%0b done=%0b expected 0 0", tx_valid_o, done_o);
        end
    endtask

    task automatic t_basic();
        mem[0] = 8'h05; mem[1] = 8'h18; mem[2] = 8'h07; mem[3] = 8'h01; mem[4] = 8'h3C; mem[5] = 8'h42;
        add_msg(6);
        pulse(1'b0, 1'b1, 6);
        wait_done(1);
        compare("R2/R4/R5 basic");
    endtask

    task automatic t_reserved();
        logic [7:0] s;
        mem[1] = 8'hA0; mem[2] = 8'h11; mem[3] = 8'hAA; mem[4] = 8'hA1;
        s = mem[1] + mem[2] + mem[3] + mem[4];
        mem[5] = 8'h56 - s;   // makes the checksum 0xAA
        add_msg(6);
        pulse(1'b0, 1'b1, 6);
        wait_done(1);
        compare("R3/R4 reserved and escaped checksum");
    endtask

    task automatic t_stall();
        for (int k = 1; k < 12; k++) mem[k] = 8'(k * 37 + 3);
        mem[7] = 8'hA1;
        hold_err = 0;
        stall_mode = 1'b1;
        add_msg(12);
        pulse(1'b0, 1'b1, 12);
        wait_done(1);
        stall_mode = 1'b0;
        compare("R9 stalled link frame");
        checks++;
        if (hold_err != 0) begin
            failures++;
            $display("FAIL R9: hold violations=%0d expected 0", hold_err);
        end
    endtask

    task automatic t_connect();
        add_ver();
        pulse(1'b1, 1'b0, 0);
        wait_done(1);
        compare("R6 version frame");
    endtask

    task automatic t_collide();
        mem[1] = 8'h2C; mem[2] = 8'h9E; mem[3] = 8'h40;
        add_ver();
        add_msg(4);
        pulse(1'b1, 1'b1, 4);
        wait_done(2);
        compare("R10 same-cycle connect and request");
    endtask

    task automatic t_held();
        for (int k = 1; k < 8; k++) mem[k] = 8'(k * 11 + 90);
        stall_mode = 1'b1;
        add_msg(8);
        add_msg(3);
        pulse(1'b0, 1'b1, 8);
        while (!tx_valid_o) @(posedge clk);
        repeat (3) @(posedge clk);
        pulse(1'b0, 1'b1, 3);
        wait_done(2);
        stall_mode = 1'b0;
        compare("R7 request held during frame");
    endtask

    task automatic t_short();
        add_msg(1);
        pulse(1'b0, 1'b1, 1);
        wait_done(1);
        compare("R11 count 1");
        add_msg(0);
        pulse(1'b0, 1'b1, 0);
        wait_done(1);
        compare("R11 count 0");
        mem[1] = 8'h33;
        add_msg(2);
        pulse(1'b0, 1'b1, 2);
        wait_done(1);
        compare("R2 count 2 single byte");
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) mem[k] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_reserved();
        t_stall();
        t_connect();
        t_collide();
        t_held();
        t_short();
        summary();
    end
endmodule